// File: doc/BRIEF.md
# SDRAM Forced-Command Issuer

This block is the firmware-driven command path of an SDRAM controller. Firmware uses it to step the memory through its power-up sequence. A small register bank sits on a simple host register bus. It holds an operating-mode field, a timer word, a configuration word, a bus-width select bit and one base-address byte per chip select. A second host port carries accesses to the SDRAM memory window.

The mode field decides what a window access does. In normal mode the access is handed unchanged to the controller's regular access path through a request/ready interface. In the other defined modes, every window access becomes exactly one SDRAM command on the command pins, whether it is a read or a write. The commands are no-operation, precharge of all banks, load-mode-register and auto-refresh. For load-mode-register, the distance of the access address from the selected chip's base becomes the mode value on the address and bank lines.

The block tracks whether a precharge-all has happened since the regular path last opened a row. A refresh requested without one is suppressed and recorded in a sticky error bit.

Top module: `sdram_force_cmd`

## Requirements
- R1: After reset, the registers read as follows: mode 0 (error bit 0), timer 0, configuration 0, width select 1, chip-select 0 base 0x40, chip-select 1 base 0x50. All command pins are high.
- R2: Registers are addressed on the register bus by byte offset: mode 0x00, timer 0x04, configuration 0x08, width select 0x0C, chip-select 0 base 0x10, chip-select 1 base 0x14. Reads are combinational. The mode field is bits 2:0 and the width select is bit 0. The bases hold BASE_W bits. Unimplemented bits read 0. Bit 31 of the mode register is the error flag; writing 1 there clears it.
- R3: With mode 000, a window access raises `nrm_req` with the access's write flag, chip select and address. `win_ready` and `win_rdata` follow `nrm_ready` and `nrm_rdata`. No command reaches the pins.
- R4: With mode 001, each window access drives the selected chip's `sd_cs_n` bit low (bit i is chip i) with RAS/CAS/WE = 1/1/1 (no-operation).
- R5: With mode 010, each window access issues RAS/CAS/WE = 0/1/0 with `sd_addr[10]` high (precharge all banks).
- R6: With mode 011, each window access issues RAS/CAS/WE = 0/0/0. The value `win_addr - (base << BASE_SHIFT)` of the selected chip goes out: its low ROW_W bits on `sd_addr` and the next BA_W bits on `sd_ba`.
- R7: With mode 100, a window access issues RAS/CAS/WE = 0/0/1 (auto-refresh) if a precharge-all was issued since the last `nrm_act` pulse. If not, it issues no command and sets the sticky error bit.
- R8: With modes 101 to 111, a window access issues no command and still completes.
- R9: A forced command is on the pins for exactly the one cycle after the access is accepted. `win_ready` pulses for one cycle in the next cycle, with `win_rdata` 0.
- R10: Outside a forced command every `sd_cs_n` bit is high, and at most one chip select is ever low.
- R11: A mode-register write made in the same cycle an access is accepted, or later during it, does not change that access's command.
- R12: After reset no row counts as open, so refresh is allowed. An `nrm_act` pulse makes a later refresh require a new precharge-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| win_req | input | 1 | Window access request, held until win_ready |
| win_we | input | 1 | Window access is a write |
| win_cs | input | 1 | Chip select of the access |
| win_addr | input | 32 | Byte address of the access |
| win_ready | output | 1 | Access completion |
| win_rdata | output | 32 | Read data of the access |
| nrm_req | output | 1 | Request to the regular access path |
| nrm_we | output | 1 | Forwarded write flag |
| nrm_cs | output | 1 | Forwarded chip select |
| nrm_addr | output | 32 | Forwarded address |
| nrm_ready | input | 1 | Regular path completion |
| nrm_rdata | input | 32 | Regular path read data |
| nrm_act | input | 1 | Pulse: regular path opened a row |
| sd_cs_n | output | 2 | SDRAM chip selects, active low |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_addr | output | 13 | SDRAM address lines |
| sd_ba | output | 2 | SDRAM bank lines |

## Verification
The assertions check these properties on every cycle:
- a forced command lasts one cycle and is followed by the ready pulse;
- A10 is high on every precharge-all;
- refresh appears only when the precharge tracker allowed it;
- at most one chip select is low, and none is low while an access is being forwarded;
- the error bit stays set until cleared.

Other behaviour needs the directed scenarios. These are the reset register values, the decoding of each mode into its encoding, and the load-mode value computed from each chip's base. They also cover the activate-then-refresh error path, the reserved modes and a mode write that lands at acceptance.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [2:0] MD_NORMAL = 3'd0;
  localparam logic [2:0] MD_NOP    = 3'd1;
  localparam logic [2:0] MD_PALL   = 3'd2;
  localparam logic [2:0] MD_LMR    = 3'd3;
  localparam logic [2:0] MD_REF    = 3'd4;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_IDLE = 3'b111;
  localparam sd_cmd_t CMD_PALL = 3'b010;
  localparam sd_cmd_t CMD_LMR  = 3'b000;
  localparam sd_cmd_t CMD_REF  = 3'b001;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DONE, ST_NORM} seq_state_t;

  localparam int IDX_MODE  = 0;
  localparam int IDX_TIMER = 1;
  localparam int IDX_CFG   = 2;
  localparam int IDX_WIDTH = 3;
  localparam int IDX_BASE  = 4;
  localparam int BASE_RST0 = 64;
  localparam int BASE_STEP = 16;
endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int BASE_W = 8,
  parameter int NUM_CS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wen,
  input  logic [REG_AW-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  input  logic                          err_set,
  output logic [2:0]                    mode,
  output logic [NUM_CS-1:0][BASE_W-1:0] cs_base
);
  localparam int IDX_W = REG_AW - 2;

  logic [IDX_W-1:0]               idx;
  logic                           aligned;
  logic [2:0]                     mode_q, mode_d;
  logic                           err_q, err_d, clr_hit;
  logic [DATA_W-1:0]              timer_q, timer_d, cfg_q, cfg_d;
  logic                           width_q, width_d;
  logic [NUM_CS-1:0][BASE_W-1:0]  base_q, base_d;

  assign idx     = reg_addr[REG_AW-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign clr_hit = reg_wen && aligned && (idx == IDX_W'(IDX_MODE)) && reg_wdata[DATA_W-1];

  always_comb begin
    mode_d  = mode_q;
    timer_d = timer_q;
    cfg_d   = cfg_q;
    width_d = width_q;
    base_d  = base_q;
    err_d   = err_q;
    if (clr_hit) err_d = 1'b0;
    if (err_set) err_d = 1'b1;
    if (reg_wen && aligned) begin
      if (idx == IDX_W'(IDX_MODE))  mode_d  = reg_wdata[2:0];
      if (idx == IDX_W'(IDX_TIMER)) timer_d = reg_wdata;
      if (idx == IDX_W'(IDX_CFG))   cfg_d   = reg_wdata;
      if (idx == IDX_W'(IDX_WIDTH)) width_d = reg_wdata[0];
      for (int i = 0; i < NUM_CS; i++)
        if (idx == IDX_W'(IDX_BASE + i)) base_d[i] = reg_wdata[BASE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_NORMAL;
      err_q   <= 1'b0;
      timer_q <= '0;
      cfg_q   <= '0;
      width_q <= 1'b1;
      for (int i = 0; i < NUM_CS; i++) base_q[i] <= BASE_W'(BASE_RST0 + BASE_STEP * i);
    end else begin
      mode_q  <= mode_d;
      err_q   <= err_d;
      timer_q <= timer_d;
      cfg_q   <= cfg_d;
      width_q <= width_d;
      base_q  <= base_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (idx == IDX_W'(IDX_MODE)) begin
        reg_rdata[2:0]        = mode_q;
        reg_rdata[DATA_W-1]   = err_q;
      end
      if (idx == IDX_W'(IDX_TIMER)) reg_rdata = timer_q;
      if (idx == IDX_W'(IDX_CFG))   reg_rdata = cfg_q;
      if (idx == IDX_W'(IDX_WIDTH)) reg_rdata[0] = width_q;
      for (int i = 0; i < NUM_CS; i++)
        if (idx == IDX_W'(IDX_BASE + i)) reg_rdata[BASE_W-1:0] = base_q[i];
    end
  end

  assign mode    = mode_q;
  assign cs_base = base_q;

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_q && !clr_hit) |-> err_q);
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ROW_W      = 13,
  parameter int BA_W       = 2,
  parameter int BASE_W     = 8,
  parameter int BASE_SHIFT = 20,
  parameter int NUM_CS     = 2,
  parameter int CS_W       = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    mode,
  input  logic [NUM_CS-1:0][BASE_W-1:0] cs_base,
  input  logic                          win_req,
  input  logic [CS_W-1:0]               win_cs,
  input  logic [ADDR_W-1:0]             win_addr,
  input  logic                          nrm_ready,
  input  logic                          nrm_act,
  output logic                          err_set,
  output logic                          in_norm,
  output logic                          done,
  output logic [NUM_CS-1:0]             sd_cs_n,
  output sd_cmd_t                       sd_cmd,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [BA_W-1:0]               sd_ba
);
  localparam int LMR_W = ROW_W + BA_W;

  seq_state_t          state_q, state_d;
  logic                clean_q, clean_d;
  logic [NUM_CS-1:0]   cs_n_q, cs_n_d, cs_sel_n;
  sd_cmd_t             cmd_q, cmd_d;
  logic [ROW_W-1:0]    addr_q, addr_d;
  logic [BA_W-1:0]     ba_q, ba_d;
  logic [ADDR_W-1:0]   base_full;
  logic [LMR_W-1:0]    lmr_val;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_sel_n[g] = (win_cs != CS_W'(g));
  end

  assign base_full = ADDR_W'(cs_base[win_cs]) << BASE_SHIFT;
  assign lmr_val   = LMR_W'(win_addr - base_full);

  always_comb begin
    state_d = state_q;
    clean_d = clean_q;
    cs_n_d  = '1;
    cmd_d   = CMD_IDLE;
    addr_d  = '0;
    ba_d    = '0;
    err_set = 1'b0;
    unique case (state_q)
      ST_IDLE: if (win_req) begin
        if (mode == MD_NORMAL) state_d = ST_NORM;
        else begin
          state_d = ST_CMD;
          unique case (mode)
            MD_NOP: cs_n_d = cs_sel_n;
            MD_PALL: begin
              cs_n_d      = cs_sel_n;
              cmd_d       = CMD_PALL;
              addr_d[10]  = 1'b1;
              clean_d     = 1'b1;
            end
            MD_LMR: begin
              cs_n_d = cs_sel_n;
              cmd_d  = CMD_LMR;
              addr_d = lmr_val[ROW_W-1:0];
              ba_d   = lmr_val[LMR_W-1:ROW_W];
            end
            MD_REF: begin
              if (clean_q) begin
                cs_n_d = cs_sel_n;
                cmd_d  = CMD_REF;
              end else err_set = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_CMD:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      ST_NORM: if (nrm_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (nrm_act) clean_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      clean_q <= 1'b1;
      cs_n_q  <= '1;
      cmd_q   <= CMD_IDLE;
      addr_q  <= '0;
      ba_q    <= '0;
    end else begin
      state_q <= state_d;
      clean_q <= clean_d;
      cs_n_q  <= cs_n_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      ba_q    <= ba_d;
    end
  end

  assign in_norm = (state_q == ST_NORM);
  assign done    = (state_q == ST_DONE);
  assign sd_cs_n = cs_n_q;
  assign sd_cmd  = cmd_q;
  assign sd_addr = addr_q;
  assign sd_ba   = ba_q;

  // R9
  cmd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sd_cs_n) |=> (&sd_cs_n));
  // R9
  ready_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sd_cs_n) |=> done);
  // R5
  pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&sd_cs_n) && sd_cmd == CMD_PALL) |-> sd_addr[10]);
  // R7
  ref_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&sd_cs_n) && sd_cmd == CMD_REF) |-> $past(clean_q));
  // R10
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sd_cs_n));
  // R3
  norm_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_norm |-> (&sd_cs_n));
endmodule

// File: rtl/sdram_force_cmd.sv
module sdram_force_cmd
  import sfc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int REG_AW     = 5,
  parameter int ROW_W      = 13,
  parameter int BA_W       = 2,
  parameter int BASE_W     = 8,
  parameter int BASE_SHIFT = 20,
  parameter int NUM_CS     = 2,
  localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              win_req,
  input  logic              win_we,
  input  logic [CS_W-1:0]   win_cs,
  input  logic [ADDR_W-1:0] win_addr,
  output logic              win_ready,
  output logic [DATA_W-1:0] win_rdata,
  output logic              nrm_req,
  output logic              nrm_we,
  output logic [CS_W-1:0]   nrm_cs,
  output logic [ADDR_W-1:0] nrm_addr,
  input  logic              nrm_ready,
  input  logic [DATA_W-1:0] nrm_rdata,
  input  logic              nrm_act,
  output logic [NUM_CS-1:0] sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BA_W-1:0]   sd_ba
);
  logic [2:0]                    mode;
  logic [NUM_CS-1:0][BASE_W-1:0] cs_base;
  logic                          err_set, in_norm, done;
  sd_cmd_t                       cmd;

  sfc_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW), .BASE_W(BASE_W), .NUM_CS(NUM_CS)) i_regs (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_set(err_set),
    .mode(mode), .cs_base(cs_base)
  );

  sfc_seq #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .BA_W(BA_W), .BASE_W(BASE_W),
            .BASE_SHIFT(BASE_SHIFT), .NUM_CS(NUM_CS), .CS_W(CS_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_base(cs_base),
    .win_req(win_req), .win_cs(win_cs), .win_addr(win_addr),
    .nrm_ready(nrm_ready), .nrm_act(nrm_act), .err_set(err_set),
    .in_norm(in_norm), .done(done), .sd_cs_n(sd_cs_n), .sd_cmd(cmd),
    .sd_addr(sd_addr), .sd_ba(sd_ba)
  );

  assign sd_ras_n  = cmd.ras_n;
  assign sd_cas_n  = cmd.cas_n;
  assign sd_we_n   = cmd.we_n;
  assign nrm_req   = in_norm;
  assign nrm_we    = win_we;
  assign nrm_cs    = win_cs;
  assign nrm_addr  = win_addr;
  assign win_ready = done | (in_norm & nrm_ready);
  assign win_rdata = in_norm ? nrm_rdata : '0;
endmodule

// File: tb/test_sdram_force_cmd.sv
module test_sdram_force_cmd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        win_req = 1'b0, win_we = 1'b0;
  logic [0:0]  win_cs = '0;
  logic [31:0] win_addr = '0;
  logic        win_ready;
  logic [31:0] win_rdata;
  logic        nrm_req, nrm_we;
  logic [0:0]  nrm_cs;
  logic [31:0] nrm_addr;
  logic        nrm_ready = 1'b0;
  logic [31:0] nrm_rdata = '0;
  logic        nrm_act = 1'b0;
  logic [1:0]  sd_cs_n;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [12:0] sd_addr;
  logic [1:0]  sd_ba;

  int checks = 0, fails = 0;
  bit finished = 0;

  sdram_force_cmd i_sdram_force_cmd (.*);

  always #10 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // Forced access: returns {cs_n, ras, cas, we, ba, addr} seen on the pins in the command cycle
  task automatic forced(input logic cs, input logic [31:0] a, input string rq,
                        output logic [19:0] pins);
    @(negedge clk); win_req = 1'b1; win_cs = cs; win_addr = a; win_we = 1'b1;
    @(negedge clk);
    pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr};
    chk({rq, " R9 no ready in command cycle"}, win_ready, 1'b0);
    @(negedge clk);
    chk({rq, " R9 ready"}, win_ready, 1'b1);
    chk({rq, " R9 rdata zero"}, win_rdata, 32'h0);
    chk({rq, " R10 pins idle after command"}, {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'b11111);
    win_req = 1'b0;
    @(negedge clk);
    chk({rq, " R9 ready one cycle"}, win_ready, 1'b0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(5'h00, d); chk("R1 mode", d, 32'h0);
    rd_reg(5'h04, d); chk("R1 timer", d, 32'h0);
    rd_reg(5'h08, d); chk("R1 cfg", d, 32'h0);
    rd_reg(5'h0C, d); chk("R1 width", d, 32'h1);
    rd_reg(5'h10, d); chk("R1 cs0 base", d, 32'h40);
    rd_reg(5'h14, d); chk("R1 cs1 base", d, 32'h50);
    chk("R1 R10 pins idle", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'b11111);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr_reg(5'h00, 32'hFFFF_FFF5); rd_reg(5'h00, d); chk("R2 mode field", d, 32'h5);
    wr_reg(5'h04, 32'hDEAD_BEEF); rd_reg(5'h04, d); chk("R2 timer", d, 32'hDEAD_BEEF);
    wr_reg(5'h08, 32'h1234_5678); rd_reg(5'h08, d); chk("R2 cfg", d, 32'h1234_5678);
    wr_reg(5'h0C, 32'hFFFF_FFFE); rd_reg(5'h0C, d); chk("R2 width", d, 32'h0);
    wr_reg(5'h10, 32'h0000_1234); rd_reg(5'h10, d); chk("R2 cs0 base", d, 32'h34);
    wr_reg(5'h14, 32'h0000_0077); rd_reg(5'h14, d); chk("R2 cs1 base", d, 32'h77);
    wr_reg(5'h10, 32'h40); wr_reg(5'h14, 32'h50); wr_reg(5'h00, 32'h0);
  endtask

  task automatic t_normal();
    @(negedge clk); win_req = 1'b1; win_we = 1'b1; win_cs = 1'b1; win_addr = 32'h0500_0010;
    @(negedge clk);
    chk("R3 nrm_req", nrm_req, 1'b1);
    chk("R3 fwd fields", {nrm_we, nrm_cs, nrm_addr}, {1'b1, 1'b1, 32'h0500_0010});
    chk("R3 waits for nrm_ready", win_ready, 1'b0);
    chk("R3 no command", sd_cs_n, 2'b11);
    nrm_ready = 1'b1; nrm_rdata = 32'hA5A5_0F0F; #1;
    chk("R3 ready follows", win_ready, 1'b1);
    chk("R3 rdata follows", win_rdata, 32'hA5A5_0F0F);
    @(negedge clk); win_req = 1'b0; nrm_ready = 1'b0;
    chk("R3 request dropped", nrm_req, 1'b0);
  endtask

  task automatic t_nop();
    logic [19:0] p;
    wr_reg(5'h00, 32'h1);
    forced(1'b0, 32'h0400_0008, "R4", p);
    chk("R4 nop cs0", p[19:15], {2'b10, 3'b111});
    forced(1'b1, 32'h0500_0000, "R4", p);
    chk("R4 nop cs1", p[19:15], {2'b01, 3'b111});
  endtask

  task automatic t_pall();
    logic [19:0] p;
    wr_reg(5'h00, 32'h2);
    forced(1'b0, 32'h0400_0000, "R5", p);
    chk("R5 precharge cmd", p[19:15], {2'b10, 3'b010});
    chk("R5 A10 high", p[10], 1'b1);
  endtask

  task automatic t_lmr();
    logic [19:0] p;
    wr_reg(5'h00, 32'h3);
    forced(1'b0, 32'h0400_0233, "R6", p);
    chk("R6 lmr cmd cs0", p[19:15], {2'b10, 3'b000});
    chk("R6 lmr value cs0", p[14:0], {2'b00, 13'h0233});
    forced(1'b1, 32'h0500_2033, "R6", p);
    chk("R6 lmr cmd cs1", p[19:15], {2'b01, 3'b000});
    chk("R6 lmr value cs1", p[14:0], {2'b01, 13'h0033});
  endtask

  task automatic t_refresh();
    logic [19:0] p;
    logic [31:0] d;
    wr_reg(5'h00, 32'h4);
    forced(1'b0, 32'h0400_0000, "R12", p);
    chk("R12 refresh allowed after reset", p[19:15], {2'b10, 3'b001});
    @(negedge clk); nrm_act = 1'b1;
    @(negedge clk); nrm_act = 1'b0;
    forced(1'b0, 32'h0400_0000, "R7", p);
    chk("R7 R12 refresh suppressed", p[19:15], {2'b11, 3'b111});
    rd_reg(5'h00, d); chk("R7 error set", d, 32'h8000_0004);
    wr_reg(5'h00, 32'h2);
    forced(1'b0, 32'h0400_0000, "R7", p);
    wr_reg(5'h00, 32'h4);
    forced(1'b1, 32'h0500_0000, "R7", p);
    chk("R7 refresh after precharge", p[19:15], {2'b01, 3'b001});
    rd_reg(5'h00, d); chk("R7 error sticky", d, 32'h8000_0004);
    wr_reg(5'h00, 32'h8000_0004);
    rd_reg(5'h00, d); chk("R7 error cleared", d, 32'h4);
  endtask

  task automatic t_reserved();
    logic [19:0] p;
    for (int m = 5; m < 8; m++) begin
      wr_reg(5'h00, m);
      forced(1'b0, 32'h0400_0000, "R8", p);
      chk("R8 reserved no command", p[19:15], {2'b11, 3'b111});
    end
  endtask

  task automatic t_modewrite();
    logic [19:0] p;
    wr_reg(5'h00, 32'h1);
    @(negedge clk); win_req = 1'b1; win_cs = 1'b0; win_addr = 32'h0400_0000;
    reg_wen = 1'b1; reg_addr = 5'h00; reg_wdata = 32'h2;
    @(negedge clk); reg_wen = 1'b0;
    p = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, 15'h0};
    chk("R11 old mode used", p[19:15], {2'b10, 3'b111});
    @(negedge clk); chk("R11 completes", win_ready, 1'b1); win_req = 1'b0;
    @(negedge clk);
    forced(1'b0, 32'h0400_0000, "R11", p);
    chk("R11 new mode next access", p[19:15], {2'b10, 3'b010});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_normal();
    t_nop();
    t_pall();
    t_lmr();
    t_refresh();
    t_reserved();
    t_modewrite();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule